// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block gathers eight interrupt request lines, ranks them with a fixed priority and raises one interrupt line to a processor. Software reaches it over a byte-wide bus with two ports: a command port (`bus_sel` = 0) and a data port (`bus_sel` = 1). The block holds three 8-bit registers. The pending-request register latches request edges. The in-service register records the requests being handled. The mask register blocks inputs. Before use, software runs a short configuration sequence. That sequence sets the vector base, the cascade identity and whether end of interrupt happens by itself.

The processor acknowledges an interrupt with two one-cycle pulses on `inta`. The first pulse picks the winning request, moves it from pending to in-service and freezes the vector. The second pulse places the 8-bit vector on `bus_rdata`. If the request has gone away by the first pulse, the controller hands out the input-7 vector and leaves the in-service register untouched. Software retires a request with an end-of-interrupt command, either for a named input or for the highest-priority input in service.

Configuration walks through the states CF_READY, CF_BASE, CF_CASC and CF_MODE:
- A command write with bit 4 set moves the block from any state to CF_BASE.
- From CF_BASE, a data write moves on to CF_CASC, or to CF_MODE if the block is in single mode, or to CF_READY if neither the cascade word nor the mode word is expected.
- From CF_CASC, a data write goes to CF_MODE or to CF_READY.
- From CF_MODE, a data write returns to CF_READY.

The acknowledge machine has two states, AK_IDLE and AK_HOLD. The first pulse moves it from AK_IDLE to AK_HOLD, and the second pulse moves it back to AK_IDLE.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the pending and in-service registers are 0x00 and the mask register is 0xFF. Command-port reads return the pending register, and `intr` is low.
- R2: A command write with bit 4 set starts configuration. It clears the mask register to 0x00, clears the pending and in-service registers, clears automatic end of interrupt and selects pending-register reads. `intr` stays low until CF_READY is reached. The next three data writes are taken in order as the base word, the cascade word and the mode word. The cascade word is skipped when bit 1 of the start word is 1 (single mode). The mode word is skipped when bit 0 of the start word is 0. None of these data writes changes the mask register.
- R3: The vector for input n is bits 7..3 of the base word, with n in bits 2..0.
- R4: The cascade word (a slave bitmask on a master, a 3-bit identity on a slave) is presented on `casc_cfg`. A new configuration start clears it to 0x00.
- R5: In CF_READY, a data write loads the mask register and a data-port read returns it. A 1 bit in the mask register stops that input from raising `intr`.
- R6: Command value 0x0B makes later command-port reads return the in-service register. Command value 0x0A makes them return the pending register.
- R7: A rising edge on `irq_in[n]` sets pending bit n one clock later. The bit clears when the input is seen low.
- R8: `intr` is high when some unmasked pending input n exists whose number is lower than every set in-service bit. Input 0 has the highest priority.
- R9: The first `inta` pulse clears the winner's pending bit and sets its in-service bit. The second pulse drives the frozen vector on `bus_rdata` for that cycle.
- R10: Command value 0x60+n clears only in-service bit n.
- R11: Command value 0x20 clears the lowest-numbered set in-service bit.
- R12: When bit 1 of the mode word is 1, the in-service bit set by the first pulse is cleared at the second pulse.
- R13: If no eligible request exists at the first pulse, the vector has 7 in bits 2..0 and the in-service register is unchanged, even when input 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, input 0 highest priority |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or the vector during the second acknowledge pulse |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| casc_cfg | output | 8 | Stored cascade word |

## Verification
A new request edge and the first acknowledge pulse can land on the same clock edge. The bench provokes this by raising input 1 in the very cycle of the first pulse while input 5 is already pending. The correct outcome is vector 0x25 with in-service 0x20, and input 1 left pending and raising `intr` afterwards. The second collision is an end-of-interrupt command that arrives while other in-service bits are still set. Here the bench judges the resulting in-service register and the priority ceiling through `intr`.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int NIN = 8;
    localparam int IDW = $clog2(NIN);
    localparam int DW  = 8;
    localparam int BW  = DW - IDW;

    typedef enum logic [1:0] {CF_READY, CF_BASE, CF_CASC, CF_MODE} cfg_state_t;
    typedef enum logic {AK_IDLE, AK_HOLD} ack_state_t;

    localparam logic [DW-1:0] OP_READ_IRR = 8'h0A;
    localparam logic [DW-1:0] OP_READ_ISR = 8'h0B;
    localparam logic [DW-1:0] OP_EOI_ANY  = 8'h20;
    localparam logic [BW-1:0] OP_EOI_ONE  = 5'b01100;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
    import pic8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           port_sel,
    input  logic [DW-1:0]  wdata,
    output logic [NIN-1:0] imr_o,
    output logic [BW-1:0]  base_o,
    output logic [DW-1:0]  casc_o,
    output logic           aeoi_o,
    output logic           sel_isr_o,
    output logic           ready_o,
    output logic           init_o,
    output logic           eoi_any_o,
    output logic           eoi_one_o,
    output logic [IDW-1:0] eoi_idx_o
);
    cfg_state_t st_q, st_d;
    logic single_q, need4_q;
    logic cmd_wr, dat_wr;

    assign cmd_wr    = wr_en && !port_sel;
    assign dat_wr    = wr_en && port_sel;
    assign init_o    = cmd_wr && wdata[4];
    assign ready_o   = (st_q == CF_READY);
    assign eoi_any_o = cmd_wr && ready_o && (wdata == OP_EOI_ANY);
    assign eoi_one_o = cmd_wr && ready_o && (wdata[DW-1:IDW] == OP_EOI_ONE);
    assign eoi_idx_o = wdata[IDW-1:0];

    always_comb begin
        st_d = st_q;
        if (init_o) begin
            st_d = CF_BASE;
        end else if (dat_wr) begin
            unique case (st_q)
                CF_READY: st_d = CF_READY;
                CF_BASE:  st_d = !single_q ? CF_CASC : (need4_q ? CF_MODE : CF_READY);
                CF_CASC:  st_d = need4_q ? CF_MODE : CF_READY;
                CF_MODE:  st_d = CF_READY;
                default:  st_d = CF_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CF_READY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_o     <= '1;
            base_o    <= '0;
            casc_o    <= '0;
            aeoi_o    <= 1'b0;
            sel_isr_o <= 1'b0;
            single_q  <= 1'b0;
            need4_q   <= 1'b0;
        end else if (init_o) begin
            imr_o     <= '0;
            casc_o    <= '0;
            aeoi_o    <= 1'b0;
            sel_isr_o <= 1'b0;
            single_q  <= wdata[1];
            need4_q   <= wdata[0];
        end else if (dat_wr) begin
            unique case (st_q)
                CF_READY: imr_o  <= wdata[NIN-1:0];
                CF_BASE:  base_o <= wdata[DW-1:IDW];
                CF_CASC:  casc_o <= wdata;
                CF_MODE:  aeoi_o <= wdata[1];
                default:  ;
            endcase
        end else if (cmd_wr && ready_o) begin
            if (wdata == OP_READ_IRR)      sel_isr_o <= 1'b0;
            else if (wdata == OP_READ_ISR) sel_isr_o <= 1'b1;
        end
    end

    // R2
    cfg_mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CF_READY && !init_o) |=> $stable(imr_o));
endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve
    import pic8_pkg::*;
(
    input  logic [NIN-1:0] irr,
    input  logic [NIN-1:0] isr,
    input  logic [NIN-1:0] imr,
    output logic           has_win,
    output logic [IDW-1:0] win_idx,
    output logic           isr_any,
    output logic [IDW-1:0] isr_top
);
    always_comb begin
        isr_any = 1'b0;
        isr_top = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (isr[i]) begin
                isr_any = 1'b1;
                isr_top = IDW'(i);
            end
        end
        has_win = 1'b0;
        win_idx = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (irr[i] && !imr[i] && (!isr_any || i < int'(isr_top))) begin
                has_win = 1'b1;
                win_idx = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/pic8_ack.sv
module pic8_ack
    import pic8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inta,
    input  logic           has_win,
    input  logic [IDW-1:0] win_idx,
    input  logic [BW-1:0]  base,
    output logic           take_o,
    output logic           spur_o,
    output logic           drive_o,
    output logic           done_real_o,
    output logic [IDW-1:0] done_idx_o,
    output logic [DW-1:0]  vec_o
);
    ack_state_t st_q, st_d;
    logic spur_q;
    logic first;

    assign first       = inta && (st_q == AK_IDLE);
    assign take_o      = first && has_win;
    assign spur_o      = first && !has_win;
    assign drive_o     = inta && (st_q == AK_HOLD);
    assign done_real_o = drive_o && !spur_q;
    assign done_idx_o  = vec_o[IDW-1:0];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AK_IDLE: if (inta) st_d = AK_HOLD;
            AK_HOLD: if (inta) st_d = AK_IDLE;
            default: st_d = AK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= AK_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o  <= '0;
            spur_q <= 1'b0;
        end else if (first) begin
            vec_o  <= {base, has_win ? win_idx : {IDW{1'b1}}};
            spur_q <= !has_win;
        end
    end

    // R9
    ack_vec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AK_HOLD && !inta) |=> $stable(vec_o));
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] irq_in,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic           bus_sel,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           intr,
    input  logic           inta,
    output logic [DW-1:0]  casc_cfg
);
    logic [NIN-1:0] irq_prev, irr_q, isr_q, imr;
    logic [NIN-1:0] rise, take_mask, clr_mask;
    logic [BW-1:0]  base;
    logic           aeoi, sel_isr, ready, init_go, eoi_any, eoi_one;
    logic [IDW-1:0] eoi_idx, win_idx, isr_top, done_idx;
    logic           has_win, isr_any, take, spur, drive, done_real;
    logic [DW-1:0]  vec;

    pic8_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .port_sel(bus_sel), .wdata(bus_wdata),
        .imr_o(imr), .base_o(base), .casc_o(casc_cfg), .aeoi_o(aeoi), .sel_isr_o(sel_isr),
        .ready_o(ready), .init_o(init_go), .eoi_any_o(eoi_any), .eoi_one_o(eoi_one),
        .eoi_idx_o(eoi_idx)
    );

    pic8_resolve u_res (
        .irr(irr_q), .isr(isr_q), .imr(imr), .has_win(has_win), .win_idx(win_idx),
        .isr_any(isr_any), .isr_top(isr_top)
    );

    pic8_ack u_ack (
        .clk(clk), .rst_n(rst_n), .inta(inta), .has_win(has_win), .win_idx(win_idx),
        .base(base), .take_o(take), .spur_o(spur), .drive_o(drive),
        .done_real_o(done_real), .done_idx_o(done_idx), .vec_o(vec)
    );

    assign rise      = irq_in & ~irq_prev;
    assign take_mask = take ? (NIN'(1) << win_idx) : '0;
    assign clr_mask  = (eoi_one ? (NIN'(1) << eoi_idx) : '0)
                     | ((eoi_any && isr_any) ? (NIN'(1) << isr_top) : '0)
                     | ((aeoi && done_real) ? (NIN'(1) << done_idx) : '0);
    assign intr      = ready && has_win;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prev <= '0;
            irr_q    <= '0;
            isr_q    <= '0;
        end else begin
            irq_prev <= irq_in;
            if (init_go) begin
                irr_q <= '0;
                isr_q <= '0;
            end else begin
                irr_q <= (irr_q & irq_in & ~take_mask) | rise;
                isr_q <= (isr_q & ~clr_mask) | take_mask;
            end
        end
    end

    always_comb begin
        if (drive)        bus_rdata = vec;
        else if (!bus_rd) bus_rdata = '0;
        else if (bus_sel) bus_rdata = imr;
        else              bus_rdata = sel_isr ? isr_q : irr_q;
    end

    // R9
    take_clears_irr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !init_go) |=> !irr_q[$past(win_idx)]);
    // R10
    eoi_one_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_one && !take && !init_go) |=> !isr_q[$past(eoi_idx)]);
    // R13
    spur_isr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spur && clr_mask == '0 && !init_go) |=> $stable(isr_q));
    // R8
    isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);
endmodule

// File: tb/sim_pic8_ctrl.sv
`timescale 1ns/1ps
module sim_pic8_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, casc_cfg;
    logic       intr;
    int n_chk = 0, n_fail = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    pic8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intr(intr),
        .inta(inta), .casc_cfg(casc_cfg)
    );

    function automatic int f_pick(logic [7:0] pend);
        for (int i = 0; i < 8; i++) if (pend[i]) return i;
        return -1;
    endfunction

    function automatic int f_vec(logic [7:0] base, int n);
        return int'({base[7:3], 3'(n)});
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_sel = sel;
        #1 v = bus_rdata; bus_rd = 1'b0;
    endtask

    task automatic ack1();
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic ack2(output logic [7:0] v);
        @(negedge clk); inta = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v);
        ack1();
        ack2(v);
    endtask

    task automatic set_irq(logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic rd_isr(output logic [7:0] v);
        wr(1'b0, 8'h0B); rd(1'b0, v); wr(1'b0, 8'h0A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk("R1 irr", v, 8'h00);
        rd(1'b1, v); chk("R1 imr", v, 8'hFF);
        chk("R1 intr", intr, 0);
        // R6 select ISR then back to IRR
        rd_isr(v); chk("R6 isr", v, 8'h00);

        // R2 R4 master configuration
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        chk("R4 casc master", casc_cfg, 8'h04);
        rd(1'b1, v); chk("R2 imr cleared", v, 8'h00);

        // R7 edge latch and withdrawal
        set_irq(8'h0C); rd(1'b0, v); chk("R7 irr set", v, 8'h0C);
        set_irq(8'h08); rd(1'b0, v); chk("R7 irr drop", v, 8'h08);
        // R5 mask blocks intr
        wr(1, 8'h08); chk("R5 masked", intr, 0);
        wr(1, 8'h00); chk("R5 unmasked", intr, 1);
        set_irq(8'h00);

        // R8 R9 R10 R11 nesting
        set_irq(8'h20); chk("R8 intr", intr, 1);
        ack(v); chk("R9 vec5", v, 8'h25); chk("R3 base", v, f_vec(8'h20, 5));
        rd_isr(v); chk("R9 isr5", v, 8'h20);
        set_irq(8'h60); chk("R8 lower blocked", intr, 0);
        set_irq(8'h64); chk("R8 higher passes", intr, 1);
        ack(v); chk("R9 vec2", v, 8'h22);
        rd_isr(v); chk("R8 nested isr", v, 8'h24);
        wr(0, 8'h20); rd_isr(v); chk("R11 ns eoi", v, 8'h20);
        chk("R8 ceiling", intr, 0);
        wr(0, 8'h67); rd_isr(v); chk("R10 other bit", v, 8'h20);
        wr(0, 8'h65); rd_isr(v); chk("R10 spec eoi", v, 8'h00);
        chk("R8 released", intr, 1);
        ack(v); chk("R9 vec6", v, 8'h26);
        wr(0, 8'h66); set_irq(8'h00);

        // R13 spurious, unmasked and masked input 7
        set_irq(8'h08); set_irq(8'h00);
        chk("R13 intr low", intr, 0);
        ack(v); chk("R13 vec", v, 8'h27);
        rd_isr(v); chk("R13 isr kept", v, 8'h00);
        wr(1, 8'h80);
        set_irq(8'h02); set_irq(8'h00);
        ack(v); chk("R13 masked7 vec", v, 8'h27);
        rd_isr(v); chk("R13 masked7 isr", v, 8'h00);
        wr(1, 8'h00);

        // R9 request edge in the cycle of the first pulse
        set_irq(8'h20);
        @(negedge clk); irq_in = 8'h22; inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        ack2(v); chk("R9 collide vec", v, 8'h25);
        rd_isr(v); chk("R9 collide isr", v, 8'h20);
        rd(1'b0, v); chk("R7 collide irr", v, 8'h02);
        chk("R8 collide intr", intr, 1);
        ack(v); chk("R9 collide second", v, 8'h21);
        wr(0, 8'h20); wr(0, 8'h20); set_irq(8'h00);
        rd_isr(v); chk("R11 drained", v, 8'h00);

        // R12 automatic end of interrupt
        wr(0, 8'h11); wr(1, 8'h48); wr(1, 8'h04); wr(1, 8'h03);
        set_irq(8'h10);
        ack1(); rd_isr(v); chk("R12 isr mid", v, 8'h10);
        ack2(v); chk("R12 vec", v, 8'h4C);
        rd_isr(v); chk("R12 isr auto", v, 8'h00);
        set_irq(8'h00);

        // R4 R3 slave configuration
        wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h01);
        chk("R4 casc slave", casc_cfg, 8'h02);
        set_irq(8'h02); ack(v); chk("R3 slave vec", v, 8'h29);
        wr(0, 8'h20); set_irq(8'h00);

        // R2 single mode with and without mode word
        wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h01);
        chk("R4 single casc", casc_cfg, 8'h00);
        wr(1, 8'h5A); rd(1'b1, v); chk("R2 single ready", v, 8'h5A);
        wr(0, 8'h12); wr(1, 8'h40); wr(1, 8'h33);
        rd(1'b1, v); chk("R2 no mode word", v, 8'h33);

        // random masks and patterns, master base 0x20
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        void'($urandom(32'd1234));
        for (int it = 0; it < 24; it++) begin
            logic [7:0] msk, pat;
            int w;
            msk = 8'($urandom);
            pat = 8'($urandom);
            if (it == 0) msk = 8'hFF;
            wr(1, msk);
            set_irq(pat);
            w = f_pick(pat & ~msk);
            chk("R8 rnd intr", intr, (w >= 0) ? 1 : 0);
            ack(v);
            chk((w >= 0) ? "R9 rnd vec" : "R13 rnd vec", v, (w >= 0) ? f_vec(8'h20, w) : 8'h27);
            rd(1'b0, v);
            chk("R7 rnd irr", v, (w >= 0) ? int'(pat & ~(8'h01 << w)) : int'(pat));
            wr(0, 8'h20);
            rd_isr(v); chk("R11 rnd isr", v, 8'h00);
            set_irq(8'h00);
        end

        report();
        $finish;
    end
endmodule